// File: doc/BRIEF.md
# NOR Flash Command Interpreter

This block stands in for a byte-wide parallel NOR flash on the device side of an asynchronous bus. It holds its own storage, a small array with a reduced address range. It watches the chip-enable, output-enable and write-enable strobes. Write cycles are decoded as a command stream, and read cycles return either array bytes, identification bytes or operation status. Real flash timing and analog behaviour are not modelled.

The bus pins are sampled on the block clock. A write cycle is the interval in which chip enable and write enable are both low. The address is taken when that interval opens, which is the later of the two falling edges. The data is taken when it closes, which is the earlier of the two rising edges. Commands are accepted only after a two-write unlock. After the unlock, program and erase run internally over several clocks. During that time reads return status bits in place of array data.

States and transitions: `ST_READ` goes to `ST_UNL1` on the first unlock write, and `ST_UNL1` goes to `ST_UNL2` on the second. From `ST_UNL2` the command byte selects `ST_AUTOSEL`, `ST_PROG_ARM` or `ST_ERASE_ARM`. `ST_PROG_ARM` goes to `ST_PROG_BUSY` on the next write. `ST_PROG_BUSY` ends in `ST_READ`, or in `ST_PROG_FAIL` if the program tried to raise a bit. `ST_ERASE_ARM` goes through `ST_ERASE_UNL1` and `ST_ERASE_UNL2` to `ST_ERASE_BUSY`, which ends in `ST_READ`. A mismatched write, or the reset byte, returns any idle state to `ST_READ`.

Top module: `flash_cmd_emu`

## Requirements
- R1: After reset the block is in read-array mode and every cell holds 0xFF. `bus_rd_en` is high exactly while CE, OE are low and WE is high. In that case `bus_rdata` carries the read value, and otherwise it is 0x00.
- R2: Address is captured when the write strobe (CE low and WE low) opens and data when it closes; address changes after the opening and data values before the closing have no effect.
- R3: The unlock is 0xAA written where A[14:0]=0x5555, then 0x55 where A[14:0]=0x2AAA (A[16:15] ignored). It is followed by a command byte at A[14:0]=0x5555: 0x90 autoselect, 0xA0 arm program, 0x80 arm erase.
- R4: Writing 0xF0 at any address returns to read-array mode from every state except while a program or erase is busy. This includes an armed program, where 0xF0 is not programmed.
- R5: In autoselect, a read with A[7:0]=0x00 returns 0x01, A[7:0]=0x01 returns 0x20, any other A[7:0] returns 0x00; further non-0xF0 writes leave autoselect in place.
- R6: A write that does not match the next expected step of an unlock or erase sequence returns to read-array mode. That write has no other effect.
- R7: A program stores old AND written at cell {A[16:14],A[5:0]} and is busy for PROG_CYCLES clocks. While it is busy, every read returns status, whatever the address.
- R8: Program status: DQ7 is the complement of bit 7 of the written byte, DQ6 inverts after each completed read, and all other bits are 0.
- R9: If a program tried to set a 0 bit to 1, then after the busy time the status holds DQ5=1 with DQ6 still toggling until 0xF0 is written. The cell still receives old AND written.
- R10: Erase needs the second unlock and then 0x30 written anywhere. Every cell of the sector A[16:14] of that last write becomes 0xFF, and other sectors are unchanged. Any other final byte returns to read mode with no erase.
- R11: Erase status: DQ3=1, DQ7=0, DQ6 toggling; after completion reads return array data (DQ7=1 for the erased cell).
- R12: Writes while a program or erase is busy, 0xF0 included, are ignored.
- R13: Cells are addressed by {A[16:14],A[5:0]}; A[13:6] do not select storage, so addresses differing only there alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; bus pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | 17 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data or status, zero outside reads |
| bus_rd_en | output | 1 | High while the block drives read data |

## Verification
A wrong internal state shows at the ports only through reads. Status bits appear where array data is expected, or array data appears where status is expected. This is visible on the first read after the faulty write, normally within four clocks of the strobe closing. A dropped unlock step is silent until the command that should follow fails to take effect. A wrong program or erase result is seen at the first read after the busy window. The toggle bit exposes a missed or doubled read count on the very next status read.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;
    localparam int DQ_W = 8;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_AUTOSEL,
        ST_PROG_ARM,
        ST_ERASE_ARM,
        ST_ERASE_UNL1,
        ST_ERASE_UNL2,
        ST_PROG_BUSY,
        ST_PROG_FAIL,
        ST_ERASE_BUSY
    } mode_e;

    localparam logic [14:0]     UNLOCK_ADDR_A = 15'h5555;
    localparam logic [14:0]     UNLOCK_ADDR_B = 15'h2AAA;
    localparam logic [DQ_W-1:0] KEY_FIRST     = 8'hAA;
    localparam logic [DQ_W-1:0] KEY_SECOND    = 8'h55;
    localparam logic [DQ_W-1:0] OP_RESET      = 8'hF0;
    localparam logic [DQ_W-1:0] OP_IDENT      = 8'h90;
    localparam logic [DQ_W-1:0] OP_PROGRAM    = 8'hA0;
    localparam logic [DQ_W-1:0] OP_ERASE_PRE  = 8'h80;
    localparam logic [DQ_W-1:0] OP_ERASE_GO   = 8'h30;
    localparam logic [DQ_W-1:0] ID_MAKER      = 8'h01;
    localparam logic [DQ_W-1:0] ID_PART       = 8'h20;
endpackage

// File: rtl/flash_bus_sense.sv
module flash_bus_sense
    import flash_emu_pkg::*;
#(
    parameter int AW = 17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce_n,
    input  logic            oe_n,
    input  logic            we_n,
    input  logic [AW-1:0]   addr,
    input  logic [DQ_W-1:0] wdata,
    output logic            wr_evt,
    output logic [AW-1:0]   evt_addr,
    output logic [DQ_W-1:0] evt_data,
    output logic            rd_act,
    output logic            rd_end
);
    logic wr_act, wr_act_q, rd_act_q;

    assign wr_act = !ce_n && !we_n;
    assign rd_act = !ce_n && !oe_n && we_n;
    assign rd_end = rd_act_q && !rd_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_act_q <= 1'b0;
            rd_act_q <= 1'b0;
            wr_evt   <= 1'b0;
            evt_addr <= '0;
            evt_data <= '0;
        end else begin
            wr_act_q <= wr_act;
            rd_act_q <= rd_act;
            wr_evt   <= wr_act_q && !wr_act;
            if (wr_act && !wr_act_q) evt_addr <= addr;
            if (wr_act_q && !wr_act) evt_data <= wdata;
        end
    end
endmodule

// File: rtl/flash_store.sv
module flash_store
    import flash_emu_pkg::*;
#(
    parameter int SECT_W = 3,
    parameter int OFF_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SECT_W+OFF_W-1:0]  rd_idx_a,
    output logic [DQ_W-1:0]          rd_data_a,
    input  logic [SECT_W+OFF_W-1:0]  rd_idx_b,
    output logic [DQ_W-1:0]          rd_data_b,
    input  logic                     wr_en,
    input  logic [SECT_W+OFF_W-1:0]  wr_idx,
    input  logic [DQ_W-1:0]          wr_data
);
    localparam int IDX_W = SECT_W + OFF_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DQ_W-1:0] cells [DEPTH];

    assign rd_data_a = cells[rd_idx_a];
    assign rd_data_b = cells[rd_idx_b];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (wr_en) begin
            cells[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_emu_pkg::*;
#(
    parameter int AW          = 17,
    parameter int SECT_W      = 3,
    parameter int OFF_W       = 6,
    parameter int PROG_CYCLES = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_evt,
    input  logic [AW-1:0]            evt_addr,
    input  logic [DQ_W-1:0]          evt_data,
    input  logic [DQ_W-1:0]          old_byte,
    output mode_e                    state,
    output logic [SECT_W+OFF_W-1:0]  prog_idx,
    output logic [DQ_W-1:0]          prog_byte,
    output logic                     arr_we,
    output logic [SECT_W+OFF_W-1:0]  arr_idx,
    output logic [DQ_W-1:0]          arr_wdata
);
    localparam int SEC_BYTES = 1 << OFF_W;
    localparam int CNT_MAX   = (SEC_BYTES > PROG_CYCLES) ? SEC_BYTES : PROG_CYCLES;
    localparam int CNT_W     = $clog2(CNT_MAX) + 1;

    mode_e            nxt;
    logic [CNT_W-1:0] cnt;
    logic [SECT_W-1:0] esect;
    logic at_a, key1_ok, key2_ok, prog_bad, prog_last, erase_last, busy;

    assign at_a       = evt_addr[14:0] == UNLOCK_ADDR_A;
    assign key1_ok    = at_a && (evt_data == KEY_FIRST);
    assign key2_ok    = (evt_addr[14:0] == UNLOCK_ADDR_B) && (evt_data == KEY_SECOND);
    assign prog_bad   = |(~old_byte & prog_byte);
    assign prog_last  = cnt == '0;
    assign erase_last = cnt == CNT_W'(SEC_BYTES - 1);
    assign busy       = (state == ST_PROG_BUSY) || (state == ST_ERASE_BUSY);

    // next-state decision
    always_comb begin
        nxt = state;
        if (busy) begin
            if (state == ST_PROG_BUSY && prog_last)
                nxt = prog_bad ? ST_PROG_FAIL : ST_READ;
            else if (state == ST_ERASE_BUSY && erase_last)
                nxt = ST_READ;
        end else if (wr_evt) begin
            if (evt_data == OP_RESET) begin
                nxt = ST_READ;
            end else begin
                unique case (state)
                    ST_READ:       nxt = key1_ok ? ST_UNL1 : ST_READ;
                    ST_UNL1:       nxt = key2_ok ? ST_UNL2 : ST_READ;
                    ST_UNL2: begin
                        if (!at_a)                         nxt = ST_READ;
                        else if (evt_data == OP_IDENT)     nxt = ST_AUTOSEL;
                        else if (evt_data == OP_PROGRAM)   nxt = ST_PROG_ARM;
                        else if (evt_data == OP_ERASE_PRE) nxt = ST_ERASE_ARM;
                        else                               nxt = ST_READ;
                    end
                    ST_AUTOSEL:    nxt = ST_AUTOSEL;
                    ST_PROG_ARM:   nxt = ST_PROG_BUSY;
                    ST_ERASE_ARM:  nxt = key1_ok ? ST_ERASE_UNL1 : ST_READ;
                    ST_ERASE_UNL1: nxt = key2_ok ? ST_ERASE_UNL2 : ST_READ;
                    ST_ERASE_UNL2: nxt = (evt_data == OP_ERASE_GO) ? ST_ERASE_BUSY : ST_READ;
                    ST_PROG_FAIL:  nxt = ST_PROG_FAIL;
                    default:       nxt = ST_READ;
                endcase
            end
        end
    end

    // state register and operation datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_READ;
            cnt       <= '0;
            esect     <= '0;
            prog_idx  <= '0;
            prog_byte <= '0;
        end else begin
            state <= nxt;
            if (state == ST_PROG_ARM && nxt == ST_PROG_BUSY) begin
                prog_idx  <= {evt_addr[AW-1 -: SECT_W], evt_addr[OFF_W-1:0]};
                prog_byte <= evt_data;
                cnt       <= CNT_W'(PROG_CYCLES - 1);
            end else if (state == ST_ERASE_UNL2 && nxt == ST_ERASE_BUSY) begin
                esect <= evt_addr[AW-1 -: SECT_W];
                cnt   <= '0;
            end else if (state == ST_PROG_BUSY) begin
                cnt <= cnt - 1'b1;
            end else if (state == ST_ERASE_BUSY) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // array write outputs
    always_comb begin
        arr_we    = 1'b0;
        arr_idx   = prog_idx;
        arr_wdata = old_byte & prog_byte;
        unique case (state)
            ST_PROG_BUSY:  arr_we = prog_last;
            ST_ERASE_BUSY: begin
                arr_we    = 1'b1;
                arr_idx   = {esect, cnt[OFF_W-1:0]};
                arr_wdata = '1;
            end
            default: arr_we = 1'b0;
        endcase
    end
endmodule

// File: rtl/flash_cmd_emu.sv
module flash_cmd_emu
    import flash_emu_pkg::*;
#(
    parameter int AW          = 17,
    parameter int SECT_W      = 3,
    parameter int OFF_W       = 6,
    parameter int PROG_CYCLES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_ce_n,
    input  logic            bus_oe_n,
    input  logic            bus_we_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DQ_W-1:0] bus_wdata,
    output logic [DQ_W-1:0] bus_rdata,
    output logic            bus_rd_en
);
    localparam int IDX_W = SECT_W + OFF_W;

    mode_e             state;
    logic              wr_evt, rd_act, rd_end, tog, arr_we;
    logic [AW-1:0]     evt_addr;
    logic [DQ_W-1:0]   evt_data, arr_byte, old_byte, prog_byte, arr_wdata, rd_val;
    logic [IDX_W-1:0]  rd_idx, prog_idx, arr_idx;
    logic              show_status;

    flash_bus_sense #(.AW(AW)) sense_i (
        .clk(clk), .rst_n(rst_n),
        .ce_n(bus_ce_n), .oe_n(bus_oe_n), .we_n(bus_we_n),
        .addr(bus_addr), .wdata(bus_wdata),
        .wr_evt(wr_evt), .evt_addr(evt_addr), .evt_data(evt_data),
        .rd_act(rd_act), .rd_end(rd_end)
    );

    assign rd_idx = {bus_addr[AW-1 -: SECT_W], bus_addr[OFF_W-1:0]};

    flash_store #(.SECT_W(SECT_W), .OFF_W(OFF_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .rd_idx_a(rd_idx), .rd_data_a(arr_byte),
        .rd_idx_b(prog_idx), .rd_data_b(old_byte),
        .wr_en(arr_we), .wr_idx(arr_idx), .wr_data(arr_wdata)
    );

    flash_cmd_fsm #(.AW(AW), .SECT_W(SECT_W), .OFF_W(OFF_W), .PROG_CYCLES(PROG_CYCLES)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .wr_evt(wr_evt), .evt_addr(evt_addr), .evt_data(evt_data),
        .old_byte(old_byte), .state(state),
        .prog_idx(prog_idx), .prog_byte(prog_byte),
        .arr_we(arr_we), .arr_idx(arr_idx), .arr_wdata(arr_wdata)
    );

    assign show_status = (state == ST_PROG_BUSY) || (state == ST_PROG_FAIL) ||
                         (state == ST_ERASE_BUSY);

    // toggle bit advances once per completed status read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     tog <= 1'b0;
        else if (rd_end && show_status) tog <= ~tog;
    end

    always_comb begin
        unique case (state)
            ST_AUTOSEL: begin
                if (bus_addr[7:0] == 8'h00)      rd_val = ID_MAKER;
                else if (bus_addr[7:0] == 8'h01) rd_val = ID_PART;
                else                             rd_val = '0;
            end
            ST_PROG_BUSY:  rd_val = {~prog_byte[7], tog, 6'b000000};
            ST_PROG_FAIL:  rd_val = {~prog_byte[7], tog, 1'b1, 5'b00000};
            ST_ERASE_BUSY: rd_val = {1'b0, tog, 2'b00, 1'b1, 3'b000};
            default:       rd_val = arr_byte;
        endcase
    end

    assign bus_rd_en = rd_act;
    assign bus_rdata = rd_act ? rd_val : '0;
endmodule

// File: rtl/flash_cmd_emu_chk.sv
module flash_cmd_emu_chk
    import flash_emu_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input mode_e           state,
    input logic            wr_evt,
    input logic [14:0]     evt_addr_lo,
    input logic [DQ_W-1:0] evt_data,
    input logic            rd_act,
    input logic [7:0]      addr_lo,
    input logic [DQ_W-1:0] bus_rdata
);
    a_r1_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act |-> bus_rdata == '0);

    a_r4_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && evt_data == OP_RESET && state != ST_PROG_BUSY && state != ST_ERASE_BUSY)
        |=> state == ST_READ);

    a_r5_part_id: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AUTOSEL && rd_act && addr_lo == 8'h01) |-> bus_rdata == ID_PART);

    a_r6_bad_second_key: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UNL1 && wr_evt && !(evt_addr_lo == UNLOCK_ADDR_B && evt_data == KEY_SECOND))
        |=> state == ST_READ);

    a_r7_prog_exit: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PROG_BUSY |=>
        (state == ST_PROG_BUSY || state == ST_READ || state == ST_PROG_FAIL));

    a_r9_fail_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG_FAIL && rd_act) |-> bus_rdata[5]);

    a_r11_erase_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE_BUSY && rd_act) |-> (bus_rdata[3] && !bus_rdata[7]));

    a_r12_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE_BUSY && wr_evt) |=> (state == ST_ERASE_BUSY || state == ST_READ));
endmodule

bind flash_cmd_emu flash_cmd_emu_chk chk_i (
    .clk(clk), .rst_n(rst_n), .state(state), .wr_evt(wr_evt),
    .evt_addr_lo(evt_addr[14:0]), .evt_data(evt_data), .rd_act(rd_act),
    .addr_lo(bus_addr[7:0]), .bus_rdata(bus_rdata)
);

// File: tb/flash_cmd_emu_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_emu_tb_top;
    localparam int AW = 17;

    localparam int M_READ = 0, M_U1 = 1, M_U2 = 2, M_AUTO = 3, M_PARM = 4, M_EARM = 5,
                   M_EU1 = 6, M_EU2 = 7, M_PBUSY = 8, M_PFAIL = 9, M_EBUSY = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          rd_en;

    int checks = 0;
    int errors = 0;

    logic [7:0] mem_m [512];
    int         mst = M_READ;
    bit         tog_m = 1'b0;
    logic [7:0] pd_m = '0;
    bit         pfail_m = 1'b0;

    always #2.5 clk = ~clk;

    flash_cmd_emu dut_i (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_rd_en(rd_en)
    );

    function automatic int idx_of(logic [AW-1:0] a);
        return int'({a[16:14], a[5:0]});
    endfunction

    function automatic bit is_status();
        return (mst == M_PBUSY) || (mst == M_PFAIL) || (mst == M_EBUSY);
    endfunction

    function automatic void model_write(logic [AW-1:0] a, logic [7:0] d);
        bit k1, k2;
        logic [7:0] old;
        k1 = (a[14:0] == 15'h5555) && (d == 8'hAA);
        k2 = (a[14:0] == 15'h2AAA) && (d == 8'h55);
        if (mst == M_PBUSY || mst == M_EBUSY) return;
        if (d == 8'hF0) begin mst = M_READ; return; end
        case (mst)
            M_READ: mst = k1 ? M_U1 : M_READ;
            M_U1:   mst = k2 ? M_U2 : M_READ;
            M_U2: begin
                if (a[14:0] != 15'h5555) mst = M_READ;
                else if (d == 8'h90)     mst = M_AUTO;
                else if (d == 8'hA0)     mst = M_PARM;
                else if (d == 8'h80)     mst = M_EARM;
                else                     mst = M_READ;
            end
            M_PARM: begin
                old = mem_m[idx_of(a)];
                pfail_m = ((~old & d) != 8'h00);
                mem_m[idx_of(a)] = old & d;
                pd_m = d;
                mst = M_PBUSY;
            end
            M_EARM: mst = k1 ? M_EU1 : M_READ;
            M_EU1:  mst = k2 ? M_EU2 : M_READ;
            M_EU2: begin
                if (d == 8'h30) begin
                    for (int i = 0; i < 64; i++) mem_m[int'(a[16:14]) * 64 + i] = 8'hFF;
                    mst = M_EBUSY;
                end else mst = M_READ;
            end
            default: ;
        endcase
    endfunction

    function automatic void model_done();
        if (mst == M_PBUSY) mst = pfail_m ? M_PFAIL : M_READ;
        else if (mst == M_EBUSY) mst = M_READ;
    endfunction

    function automatic logic [7:0] model_read(logic [AW-1:0] a);
        case (mst)
            M_AUTO:  return (a[7:0] == 8'h00) ? 8'h01 : (a[7:0] == 8'h01) ? 8'h20 : 8'h00;
            M_PBUSY: return {~pd_m[7], tog_m, 6'b0};
            M_PFAIL: return {~pd_m[7], tog_m, 1'b1, 5'b0};
            M_EBUSY: return {1'b0, tog_m, 2'b00, 1'b1, 3'b000};
            default: return mem_m[idx_of(a)];
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [AW-1:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (4) @(negedge clk);
        model_write(a, d);
    endtask

    // address changes after the strobe opens, data settles only before it closes
    task automatic bus_write_late(logic [AW-1:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = ~d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        addr = a ^ 17'h07FFF; wdata = d;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (4) @(negedge clk);
        model_write(a, d);
    endtask

    task automatic bus_read(logic [AW-1:0] a, string tag, output logic [7:0] got);
        logic [7:0] exp;
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        got = rdata;
        exp = model_read(a);
        check(tag, got, exp);
        oe_n = 1'b1; ce_n = 1'b1;
        repeat (2) @(negedge clk);
        if (is_status()) tog_m = ~tog_m;
    endtask

    task automatic unlock(logic [AW-1:0] base);
        bus_write(base | 17'h05555, 8'hAA);
        bus_write(base | 17'h02AAA, 8'h55);
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
        model_done();
    endtask

    // R1: read-enable compared every clock against the bench's own strobe drive
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            checks++;
            if (rd_en !== (!ce_n && !oe_n && we_n)) begin
                errors++;
                $display("FAIL R1 rd_en actual=%0b expected=%0b", rd_en, (!ce_n && !oe_n && we_n));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v0, v1;
        for (int i = 0; i < 512; i++) mem_m[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        check("R1 idle bus zero", rdata, 8'h00);
        bus_read(17'h00000, "R1 erased after reset", v0);
        bus_read(17'h1C03F, "R1 erased top sector", v0);

        // R3 / R7 / R8: program 0x5A
        unlock(17'h0);
        bus_write(17'h05555, 8'hA0);
        bus_write(17'h00012, 8'h5A);
        bus_read(17'h00012, "R8 program status 1", v0);
        bus_read(17'h12345, "R7 R8 program status any addr", v1);
        check("R8 DQ6 toggles", v0[6] ^ v1[6], 8'h01);
        settle(40);
        bus_read(17'h00012, "R7 programmed value", v0);
        bus_read(17'h01F12, "R13 alias via A13..A6", v0);
        bus_read(17'h04012, "R13 other sector untouched", v0);

        // R9: program raising bits
        unlock(17'h0);
        bus_write(17'h05555, 8'hA0);
        bus_write(17'h00012, 8'hA5);
        settle(40);
        bus_read(17'h00012, "R9 fail status", v0);
        bus_read(17'h00012, "R9 fail status again", v1);
        check("R9 DQ5 set", v0[5], 1'b1);
        check("R9 DQ6 still toggles", v0[6] ^ v1[6], 8'h01);
        bus_write(17'h00000, 8'hF0);
        bus_read(17'h00012, "R9 R4 cell holds AND", v0);

        // R5 autoselect, entered with A16:15 set (R3 ignores them)
        bus_write(17'h1D555, 8'hAA);
        bus_write(17'h1AAAA, 8'h55);
        bus_write(17'h05555, 8'h90);
        bus_read(17'h00000, "R5 R3 maker id", v0);
        bus_read(17'h00001, "R5 part id", v0);
        bus_read(17'h00005, "R5 other offset", v0);
        bus_write(17'h00033, 8'h12);
        bus_read(17'h04001, "R5 stays after write", v0);
        bus_write(17'h00000, 8'hF0);
        bus_read(17'h00001, "R4 back to array", v0);

        // R6: broken sequences
        bus_write(17'h05555, 8'hAA);
        bus_write(17'h01234, 8'h55);
        bus_write(17'h05555, 8'hA0);
        bus_write(17'h00030, 8'h00);
        bus_read(17'h00030, "R6 wrong address no program", v0);
        unlock(17'h0);
        bus_write(17'h05555, 8'h77);
        bus_write(17'h00031, 8'h00);
        bus_read(17'h00031, "R6 bad command no program", v0);

        // R4: reset mid sequence and in armed program
        bus_write(17'h05555, 8'hAA);
        bus_write(17'h00100, 8'hF0);
        bus_write(17'h02AAA, 8'h55);
        bus_write(17'h05555, 8'hA0);
        bus_write(17'h00032, 8'h00);
        bus_read(17'h00032, "R4 reset mid unlock", v0);
        unlock(17'h0);
        bus_write(17'h05555, 8'hA0);
        bus_write(17'h00033, 8'hF0);
        bus_read(17'h00033, "R4 reset in armed program", v0);

        // R2: late address change and late data
        bus_write_late(17'h05555, 8'hAA);
        bus_write_late(17'h02AAA, 8'h55);
        bus_write_late(17'h05555, 8'hA0);
        bus_write_late(17'h00040, 8'h0F);
        settle(40);
        bus_read(17'h00040, "R2 capture points", v0);

        // data in sector 1 for R10
        unlock(17'h0);
        bus_write(17'h05555, 8'hA0);
        bus_write(17'h04020, 8'h11);
        settle(40);

        // R10 / R11 / R12: erase sector 0
        unlock(17'h0);
        bus_write(17'h05555, 8'h80);
        unlock(17'h0);
        bus_write(17'h00007, 8'h30);
        bus_read(17'h00012, "R11 erase status", v0);
        bus_read(17'h00012, "R11 erase status again", v1);
        check("R11 DQ6 toggles", v0[6] ^ v1[6], 8'h01);
        bus_write(17'h00000, 8'hF0);
        bus_read(17'h00040, "R12 busy ignores reset", v0);
        check("R12 DQ3 still set", v0[3], 1'b1);
        settle(100);
        bus_read(17'h00012, "R10 R11 erased cell", v0);
        bus_read(17'h00040, "R10 erased cell 2", v0);
        bus_read(17'h04020, "R10 other sector kept", v0);

        // R10: wrong final byte
        unlock(17'h0);
        bus_write(17'h05555, 8'h80);
        unlock(17'h0);
        bus_write(17'h04000, 8'h31);
        repeat (80) @(negedge clk);
        bus_read(17'h04020, "R10 R6 no erase on wrong byte", v0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule